// File: doc/BRIEF.md
# Mode-Decoded One-Time Programmable Byte Memory

This block is a synthesizable behavioural model of a byte-wide memory that can be written only by clearing bits. Its read port is controlled by active-low chip-enable and output-enable inputs, and an active-low program strobe sits beside them. Two level flags complete the control set: one says the programming supply is raised, and one says the high-voltage identifier level is present on address bit 9. From these inputs the block works out one of eight operating modes. These are read, output disable, standby, program, program-verify, program-inhibit, identifier, and a catch-all for illegal combinations. It then either drives a byte or releases the bus.

The block is fully synchronous. The mode is decoded from the inputs in the current cycle. The output register updates at the next clock edge, and any array update happens at that same edge. An output-valid qualifier stands in for the tri-state buffer. A bit that has been programmed to zero returns to one only through a synchronous erase input, which blanks the whole array. A parameter sets how many separate program strobes one byte must receive before its zeros take effect. This lets a controller's retry-and-verify path be tested against the model.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset `bus_valid_o` is 0, `bus_data_o` is 0x00, and every byte of the array reads as 0xFF.
- R2: The read mode is supply flag 0, identifier flag 0, `ce_n_i` 0 and `oe_n_i` 0, with `prog_n_i` ignored. In this mode, one clock later `bus_valid_o` is 1 and `bus_data_o` holds the byte at `addr_i`.
- R3: With supply flag 0 and identifier flag 0, `oe_n_i` 1 (output disable) or `ce_n_i` 1 (standby) gives `bus_valid_o` 0 and `bus_data_o` 0x00 one clock later. Whenever `bus_valid_o` is 0, `bus_data_o` is 0x00.
- R4: The program mode is supply flag 1, identifier flag 0, `ce_n_i` 0, `oe_n_i` 1 and `prog_n_i` 0. Entering this mode from any other mode counts as one strobe on `addr_i`. Once a byte has collected `STROBES_PER_WRITE` strobes, the edge ending that cycle stores `old AND wr_data_i` and sets the byte's count back to zero. The outputs stay released while in program mode.
- R5: Programming never turns a stored 0 into a 1. A second program of an already written byte yields the AND of both data words.
- R6: The program-verify mode is supply flag 1, identifier flag 0, `ce_n_i` 0, `oe_n_i` 0 and `prog_n_i` 1. In this mode, one clock later the block drives the stored byte, including a write made in the cycle just before.
- R7: With supply flag 1, `ce_n_i` 1, or `prog_n_i` 1 together with `oe_n_i` 1, inhibits programming. The array and the strobe counts are left unchanged and the outputs are released.
- R8: The identifier mode is supply flag 0, identifier flag 1, `ce_n_i` 0, `oe_n_i` 0 and `addr_i[ADDR_W-1:1]` all zero. In this mode, one clock later the block drives 0x97 when `addr_i[0]` is 0 and 0xD6 when it is 1.
- R9: Every other combination releases the outputs and leaves the array unchanged. This covers the identifier flag with a nonzero upper address or with an enable high, both flags set together, and supply flag 1 with `ce_n_i`, `oe_n_i` and `prog_n_i` all 0.
- R10: `erase_i` high at a clock edge sets every byte to 0xFF and clears every pending strobe count. It takes priority over a program in the same cycle.
- R11: With `STROBES_PER_WRITE` greater than 1, fewer strobes leave the byte unchanged. Counts survive verify cycles in between. Holding the program combination for several cycles counts as a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, blanks the array |
| erase_i | input | 1 | Synchronous full-array erase to 0xFF |
| addr_i | input | ADDR_W | Byte address |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| prog_n_i | input | 1 | Active-low program strobe |
| vpp_hi_i | input | 1 | Programming supply raised |
| id_hv_i | input | 1 | Identifier level present on address bit 9 |
| wr_data_i | input | 8 | Data to program |
| bus_data_o | output | 8 | Registered output byte, 0x00 when released |
| bus_valid_o | output | 1 | Output buffer enabled (tri-state qualifier) |

## Verification
The main function is tested in several ways. First, every address is read after reset. Then directed program-then-verify pairs are run: a first write shows the AND with the blank 0xFF, and a second write to the same byte shows that bits are only ever cleared. Held and repeated program combinations are run on a second instance that needs three strobes; this separates edge-counted strobes from level-counted ones and shows whether counts survive a verify or are wiped by erase. Constrained-random control mixes, concentrated on a few addresses so that writes collide, set every illegal combination against the legal ones. The identifier codes are checked against array reads at the same address.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_OUTDIS  = 3'd1,
        MD_STANDBY = 3'd2,
        MD_PROG    = 3'd3,
        MD_VERIFY  = 3'd4,
        MD_INHIBIT = 3'd5,
        MD_IDENT   = 3'd6,
        MD_INVALID = 3'd7
    } otp_mode_e;

    localparam logic [7:0] MAKER_CODE = 8'h97;
    localparam logic [7:0] PART_CODE  = 8'hD6;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    function automatic logic mode_drives_bus(otp_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
    endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              prog_n_i,
    input  logic              vpp_hi_i,
    input  logic              id_hv_i,
    output otp_mode_e         mode_o
);

    logic upper_clear;

    always_comb begin
        upper_clear = (addr_i[ADDR_W-1:1] == '0);
        mode_o      = MD_INVALID;
        if (!vpp_hi_i) begin
            if (id_hv_i) begin
                if (!ce_n_i && !oe_n_i && upper_clear) mode_o = MD_IDENT;
            end else if (ce_n_i) begin
                mode_o = MD_STANDBY;
            end else if (oe_n_i) begin
                mode_o = MD_OUTDIS;
            end else begin
                mode_o = MD_READ;
            end
        end else if (!id_hv_i) begin
            if (ce_n_i)                     mode_o = MD_INHIBIT;
            else if (!oe_n_i && prog_n_i)   mode_o = MD_VERIFY;
            else if (oe_n_i && !prog_n_i)   mode_o = MD_PROG;
            else if (oe_n_i && prog_n_i)    mode_o = MD_INHIBIT;
        end
    end

endmodule

// File: rtl/otp_array.sv
module otp_array
    import otp_pkg::*;
#(
    parameter int ADDR_W            = 8,
    parameter int STROBES_PER_WRITE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              prog_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              commit_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = (STROBES_PER_WRITE < 2) ? 1 : $clog2(STROBES_PER_WRITE + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0]    mem;
        logic [DEPTH-1:0][CW-1:0] cnt;
        logic                     prev_prog;
    } arr_st_t;

    arr_st_t st_d, st_q;
    logic    strobe;

    always_comb begin
        st_d           = st_q;
        commit_o       = 1'b0;
        strobe         = prog_i && !st_q.prev_prog;
        st_d.prev_prog = prog_i;
        if (erase_i) begin
            st_d.mem = '1;
            st_d.cnt = '0;
        end else if (strobe) begin
            if (int'(st_q.cnt[addr_i]) + 1 >= STROBES_PER_WRITE) begin
                st_d.mem[addr_i] = st_q.mem[addr_i] & wdata_i;
                st_d.cnt[addr_i] = '0;
                commit_o         = 1'b1;
            end else begin
                st_d.cnt[addr_i] = st_q.cnt[addr_i] + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem       <= '1;
            st_q.cnt       <= '0;
            st_q.prev_prog <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.mem[addr_i];

    // R10: after an erase edge the addressed byte is blank
    a_r10_erase_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (st_q.mem[$past(addr_i)] == BLANK_BYTE));

    // R5: a committed write never raises a bit
    a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> ((st_q.mem[$past(addr_i)] & ~$past(st_q.mem[addr_i])) == 8'h00));

    // R7 / R9: no program and no erase means the array holds
    a_r7_array_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_i && !erase_i) |=> $stable(st_q.mem));

    // R11: a held program combination commits at most on its first cycle
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_i && $past(prog_i)) |-> !commit_o);

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
    import otp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  otp_mode_e mode_i,
    input  logic      addr_lsb_i,
    input  logic [7:0] rdata_i,
    output logic [7:0] data_o,
    output logic      valid_o
);

    typedef struct packed {
        logic [7:0] data;
        logic       valid;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        unique case (mode_i)
            MD_READ, MD_VERIFY: begin
                st_d.valid = 1'b1;
                st_d.data  = rdata_i;
            end
            MD_IDENT: begin
                st_d.valid = 1'b1;
                st_d.data  = addr_lsb_i ? PART_CODE : MAKER_CODE;
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

    // R3: a released bus carries zero
    a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (data_o == 8'h00));

    // R3: disable and standby release the bus one cycle later
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MD_OUTDIS) || (mode_i == MD_STANDBY)) |=> !valid_o);

    // R8: identifier with low address bit 0 returns the maker code
    a_r8_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MD_IDENT) && !addr_lsb_i) |=> (valid_o && data_o == MAKER_CODE));

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
    import otp_pkg::*;
#(
    parameter int ADDR_W            = 8,
    parameter int STROBES_PER_WRITE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              prog_n_i,
    input  logic              vpp_hi_i,
    input  logic              id_hv_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        bus_data_o,
    output logic              bus_valid_o
);

    otp_mode_e  mode;
    logic [7:0] rdata;
    logic       commit;

    otp_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i   (addr_i),
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .prog_n_i (prog_n_i),
        .vpp_hi_i (vpp_hi_i),
        .id_hv_i  (id_hv_i),
        .mode_o   (mode)
    );

    otp_array #(
        .ADDR_W            (ADDR_W),
        .STROBES_PER_WRITE (STROBES_PER_WRITE)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_i  (erase_i),
        .prog_i   (mode == MD_PROG),
        .addr_i   (addr_i),
        .wdata_i  (wr_data_i),
        .rdata_o  (rdata),
        .commit_o (commit)
    );

    otp_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .addr_lsb_i (addr_i[0]),
        .rdata_i    (rdata),
        .data_o     (bus_data_o),
        .valid_o    (bus_valid_o)
    );

    // R4: a write only lands under the program pin combination
    a_r4_commit_needs_prog: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (vpp_hi_i && !id_hv_i && !ce_n_i && oe_n_i && !prog_n_i));

    // R7: raised supply with chip enable high never programs
    a_r7_ce_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi_i && ce_n_i) |-> !commit);

    // R9: both flags set together release the bus
    a_r9_flags_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi_i && id_hv_i) |=> !bus_valid_o);

    // R6: verify drives the bus one cycle later
    a_r6_verify_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi_i && !id_hv_i && !ce_n_i && !oe_n_i && prog_n_i) |=> bus_valid_o);

endmodule

// File: tb/otp_byte_mem_tb.sv
`timescale 1ns/1ps
module otp_byte_mem_tb;

    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int K_READ = 0, K_OFF = 1, K_PROG = 2, K_VER = 3, K_INH = 4, K_ID = 5, K_BAD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1, vpp = 1'b0, idhv = 1'b0;
    logic [7:0] wdat = 8'h00;
    logic [7:0] d1_data, d3_data;
    logic d1_val, d3_val;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    bit [7:0] m_mem [2][DEPTH];
    int       m_cnt [2][DEPTH];
    bit       m_prev;
    int       need [2] = '{1, 3};

    always #2.5 clk = ~clk;

    otp_byte_mem #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .erase_i(erase), .addr_i(addr), .ce_n_i(ce_n),
        .oe_n_i(oe_n), .prog_n_i(prog_n), .vpp_hi_i(vpp), .id_hv_i(idhv),
        .wr_data_i(wdat), .bus_data_o(d1_data), .bus_valid_o(d1_val));

    otp_byte_mem #(.ADDR_W(AW), .STROBES_PER_WRITE(3)) u_dut3 (
        .clk(clk), .rst_n(rst_n), .erase_i(erase), .addr_i(addr), .ce_n_i(ce_n),
        .oe_n_i(oe_n), .prog_n_i(prog_n), .vpp_hi_i(vpp), .id_hv_i(idhv),
        .wr_data_i(wdat), .bus_data_o(d3_data), .bus_valid_o(d3_val));

    function automatic int f_mode(bit h, bit i, bit c, bit o, bit p, logic [AW-1:0] a);
        if (!h) begin
            if (i) return (!c && !o && a[AW-1:1] == 0) ? K_ID : K_BAD;
            return (!c && !o) ? K_READ : K_OFF;
        end
        if (i) return K_BAD;
        if (c) return K_INH;
        if (!o && p) return K_VER;
        if (o && !p) return K_PROG;
        if (o && p) return K_INH;
        return K_BAD;
    endfunction

    function automatic string f_tag(int m);
        case (m)
            K_READ:  return "R2";
            K_OFF:   return "R3";
            K_PROG:  return "R4";
            K_VER:   return "R6";
            K_INH:   return "R7";
            K_ID:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual valid/data=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(bit h, bit i, bit c, bit o, bit p, logic [AW-1:0] a,
                         logic [7:0] d, bit er, string tag);
        int md;
        logic [8:0] ex [2];
        bit strobe;
        vpp = h; idhv = i; ce_n = c; oe_n = o; prog_n = p; addr = a; wdat = d; erase = er;
        md = f_mode(h, i, c, o, p, a);
        for (int k = 0; k < 2; k++) begin
            if (md == K_READ || md == K_VER) ex[k] = {1'b1, m_mem[k][a]};
            else if (md == K_ID)             ex[k] = {1'b1, a[0] ? 8'hD6 : 8'h97};
            else                             ex[k] = 9'h000;
        end
        strobe = (md == K_PROG) && !m_prev;
        m_prev = (md == K_PROG);
        for (int k = 0; k < 2; k++) begin
            if (er) begin
                for (int j = 0; j < DEPTH; j++) begin m_mem[k][j] = 8'hFF; m_cnt[k][j] = 0; end
            end else if (strobe) begin
                if (m_cnt[k][a] + 1 >= need[k]) begin
                    m_mem[k][a] = m_mem[k][a] & d; m_cnt[k][a] = 0;
                end else m_cnt[k][a]++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check((tag != "") ? tag : f_tag(md), {d1_val, d1_data}, ex[0]);
        check((tag != "") ? tag : "R11", {d3_val, d3_data}, ex[1]);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        cycle(0, 0, 0, 0, 1, a, 8'h00, 0, tag);
    endtask

    task automatic pg(logic [AW-1:0] a, logic [7:0] d, string tag);
        cycle(1, 0, 0, 1, 0, a, d, 0, tag);
        cycle(1, 0, 0, 1, 1, a, d, 0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 2; k++)
            for (int j = 0; j < DEPTH; j++) begin m_mem[k][j] = 8'hFF; m_cnt[k][j] = 0; end
        m_prev = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", {d1_val, d1_data}, 9'h000);
        check("R1", {d3_val, d3_data}, 9'h000);
        for (int j = 0; j < DEPTH; j++) rd(AW'(j), "R1");

        // R4 / R6: first write then verify
        pg(8'd3, 8'h5A, "R4");
        cycle(1, 0, 0, 0, 1, 8'd3, 8'h00, 0, "R6");
        // R5: rewrite only clears bits
        pg(8'd3, 8'hF0, "R5");
        cycle(1, 0, 0, 0, 1, 8'd3, 8'hFF, 0, "R5");
        rd(8'd3, "R2");
        // R6: verify right after a strobe sees the new value
        cycle(1, 0, 0, 1, 0, 8'd4, 8'h0F, 0, "R4");
        cycle(1, 0, 0, 0, 1, 8'd4, 8'h00, 0, "R6");
        // R3: output disable and standby
        cycle(0, 0, 0, 1, 1, 8'd3, 8'h00, 0, "R3");
        cycle(0, 0, 1, 0, 0, 8'd3, 8'h00, 0, "R3");
        // R11: held strobe counts once, counts survive verify
        cycle(1, 0, 0, 1, 0, 8'd7, 8'h00, 0, "R11");
        cycle(1, 0, 0, 1, 0, 8'd7, 8'h00, 0, "R11");
        cycle(1, 0, 0, 1, 0, 8'd7, 8'h00, 0, "R11");
        cycle(1, 0, 0, 0, 1, 8'd7, 8'h00, 0, "R11");
        pg(8'd7, 8'h00, "R11");
        cycle(1, 0, 0, 0, 1, 8'd7, 8'h00, 0, "R11");
        pg(8'd7, 8'h00, "R11");
        rd(8'd7, "R11");
        // R7: inhibit combinations leave data alone
        cycle(1, 0, 1, 1, 0, 8'd9, 8'h00, 0, "R7");
        cycle(1, 0, 0, 1, 1, 8'd9, 8'h00, 0, "R7");
        rd(8'd9, "R7");
        // R8 / R9: identifier and illegal combinations
        cycle(0, 1, 0, 0, 1, 8'd0, 8'h00, 0, "R8");
        cycle(0, 1, 0, 0, 0, 8'd1, 8'h00, 0, "R8");
        cycle(0, 1, 0, 0, 1, 8'd2, 8'h00, 0, "R9");
        cycle(0, 1, 0, 1, 1, 8'd0, 8'h00, 0, "R9");
        cycle(1, 1, 0, 1, 0, 8'd9, 8'h00, 0, "R9");
        cycle(1, 0, 0, 0, 0, 8'd9, 8'h00, 0, "R9");
        rd(8'd9, "R9");
        // R10: erase wins over program, clears counts
        cycle(1, 0, 0, 1, 0, 8'd11, 8'h00, 0, "R10");
        cycle(1, 0, 0, 1, 1, 8'd11, 8'h00, 0, "R10");
        cycle(1, 0, 0, 1, 0, 8'd11, 8'h00, 0, "R10");
        cycle(1, 0, 0, 1, 1, 8'd11, 8'h00, 0, "R10");
        cycle(1, 0, 0, 1, 0, 8'd12, 8'h00, 1, "R10");
        cycle(1, 0, 0, 1, 1, 8'd12, 8'h00, 0, "R10");
        pg(8'd11, 8'h00, "R10");
        rd(8'd3, "R10");
        rd(8'd11, "R10");
        rd(8'd12, "R10");

        for (int n = 0; n < 2500; n++) begin
            logic [AW-1:0] a;
            bit h, i, c, o, p, e;
            a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 8);
            h = ($urandom % 2) == 1;
            i = ($urandom % 12) == 0;
            c = ($urandom % 4) == 0;
            o = ($urandom % 2) == 1;
            p = ($urandom % 2) == 1;
            e = ($urandom % 150) == 0;
            cycle(h, i, c, o, p, a, 8'($urandom), e, "");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule